// File: doc/BRIEF.md
# Per-Thread Reorder Slot Budget Tracker

This block keeps the slot accounting for a reorder buffer that several hardware threads share. Each thread sends a strobe when it claims a slot and a strobe when it frees one. The block counts the slots each thread holds and the total in use. It reports, for each thread, how much of its budget is left, and it reports how much room the whole buffer has. The payload store, commit and squash logic sit outside this block and only see the counts and the stall lines.

A thread's budget is called its ceiling. A two-bit sharing mode selects how ceilings are set. In the shared mode every thread may use the whole buffer. In the split mode the buffer is divided evenly among the threads that are currently active. In the capped mode every thread is limited to a programmable cap, except that a thread running alone gets the whole buffer. Ceilings are derived again on every clock from the sampled mode, cap and active mask. A change in any of these therefore shows at the outputs one cycle later.

The allocate port hands out slots lowest thread first. It never grants more slots in one cycle than the free room that was registered at the start of that cycle. Up to four threads are supported, and the total depth is a parameter.

Top module: `rob_slot_alloc`

## Requirements
- R1: Mode code 2'b00 (shared), and the unused code 2'b11, give every thread a ceiling equal to DEPTH.
- R2: Mode code 2'b01 (split) gives each active thread a ceiling of DEPTH divided by the number of active threads, with the remainder discarded. Inactive threads get DEPTH/NTHR, and an all-zero mask gives every thread DEPTH/NTHR.
- R3: Mode code 2'b10 (capped) gives every thread a ceiling of min(cap_limit, DEPTH). If exactly one thread is active, that thread's ceiling is DEPTH instead.
- R4: Ceilings are registered from the mode, cap and mask sampled at each clock edge, so a change in any of them reaches the outputs one cycle later.
- R5: Field t of thread_free (bits t*CW and up) equals the thread's ceiling minus its occupancy, or 0 when the occupancy is at or above the ceiling.
- R6: total_free equals DEPTH minus the sum of all thread occupancies and never exceeds DEPTH.
- R7: thread_stall[t] is 1 exactly when the thread's free count is 0 or total_free is 0.
- R8: alloc_req[t] is granted only when thread t has free room. Grants go in ascending thread order, and no more are given in a cycle than the total_free value at the start of that cycle. Each grant raises the thread's occupancy and the total by one. Requests that are not granted leave the counts unchanged.
- R9: retire_req[t] lowers the occupancy of thread t and the total by one. A retire to a thread whose occupancy is already 0 is ignored.
- R10: A granted allocate and a valid retire to the same thread in the same cycle leave that thread's occupancy unchanged.
- R11: A clock edge with rst_n low clears every occupancy. It loads the ceilings from the current mode and cap as if all threads were active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 2 | Sharing mode: 00 shared, 01 split, 10 capped, 11 as shared |
| cap_limit | input | CW | Per-thread cap used in the capped mode |
| thread_active | input | NTHR | One bit per thread, 1 = active |
| alloc_req | input | NTHR | Per-thread slot claim strobe |
| retire_req | input | NTHR | Per-thread slot release strobe |
| thread_free | output | NTHR*CW | Per-thread remaining budget, CW bits per thread |
| total_free | output | CW | Free slots in the whole buffer |
| thread_stall | output | NTHR | Per-thread stall, 1 = no slot may be claimed |

## Verification
The bench builds the block with NTHR=4 and DEPTH=10. With that depth a full buffer is reached in ten claims, and the split mode meets uneven division: 10/3 and 10/4 both drop a remainder. A cap of 15 can be driven, which is above the depth, so the clamp in the capped mode is exercised. The depth is also small enough that random traffic often reaches both the single-slot-left arbitration case and ceilings that fall below the current occupancy.

// File: rtl/rob_alloc_pkg.sv
// Shared type for the slot budget tracker: the sharing-mode encoding.
package rob_alloc_pkg;
    typedef enum logic [1:0] {
        POL_SHARED = 2'b00,
        POL_SPLIT  = 2'b01,
        POL_CAP    = 2'b10,
        POL_RSVD   = 2'b11
    } share_pol_e;
endpackage

// File: rtl/rob_ceiling_calc.sv
// Combinational ceiling generator. Maps the mode, cap and active mask to a
// per-thread ceiling. Assumes NTHR <= 4, so the split divisor comes from a
// four-entry lookup of constant quotients. Remainders are dropped.
module rob_ceiling_calc
    import rob_alloc_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [1:0]         pol_i,
    input  logic [CW-1:0]      cap_i,
    input  logic [NTHR-1:0]    act_i,
    output logic [NTHR*CW-1:0] ceil_o
);
    localparam int AW = $clog2(NTHR + 1);
    localparam logic [CW-1:0] FULL  = CW'(DEPTH);
    localparam logic [CW-1:0] EVEN  = CW'(DEPTH / NTHR);

    logic [AW-1:0] n_act;
    logic [CW-1:0] share;
    logic [CW-1:0] cap_clamped;

    // Count active threads and pick the even share from the lookup.
    always_comb begin
        n_act = '0;
        for (int t = 0; t < NTHR; t++) n_act = n_act + AW'(act_i[t]);
        case (n_act)
            AW'(1):  share = FULL;
            AW'(2):  share = CW'(DEPTH / 2);
            AW'(3):  share = CW'(DEPTH / 3);
            AW'(4):  share = CW'(DEPTH / 4);
            default: share = EVEN;
        endcase
        cap_clamped = (cap_i > FULL) ? FULL : cap_i;
    end

    // Per-thread ceiling selection by mode.
    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            case (share_pol_e'(pol_i))
                POL_SPLIT: ceil_o[t*CW +: CW] = act_i[t] ? share : EVEN;
                POL_CAP:   ceil_o[t*CW +: CW] = (act_i[t] && n_act == AW'(1)) ? FULL : cap_clamped;
                default:   ceil_o[t*CW +: CW] = FULL;
            endcase
        end
    end
endmodule

// File: rtl/rob_occ_counter.sv
// Occupancy counter for one thread. Assumes the caller raises dec_i only
// when the count is non-zero and inc_i only when room exists.
module rob_occ_counter #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] occ_o
);
    // Count up on claim, down on release, hold when both or neither.
    always_ff @(posedge clk) begin
        if (!rst_n)              occ_o <= '0;
        else if (inc_i && !dec_i) occ_o <= occ_o + CW'(1);
        else if (dec_i && !inc_i) occ_o <= occ_o - CW'(1);
    end
endmodule

// File: rtl/rob_grant_arb.sv
// Claim arbiter. Grants requests in ascending thread order to threads with
// room, and never grants more in one cycle than the registered free total.
module rob_grant_arb #(
    parameter int NTHR = 4,
    parameter int CW   = 6
) (
    input  logic [NTHR-1:0] req_i,
    input  logic [NTHR-1:0] room_i,
    input  logic [CW-1:0]   glob_free_i,
    output logic [NTHR-1:0] grant_o
);
    logic [CW-1:0] used;

    // Walk threads from 0 upward, spending the global room.
    always_comb begin
        used    = '0;
        grant_o = '0;
        for (int t = 0; t < NTHR; t++) begin
            if (req_i[t] && room_i[t] && (used < glob_free_i)) begin
                grant_o[t] = 1'b1;
                used       = used + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rob_slot_alloc.sv
// Reorder-buffer slot budget tracker for up to four threads. Holds one
// occupancy per thread plus a global total, a registered ceiling per
// thread, and derives free counts and stall lines from them.
module rob_slot_alloc #(
    parameter int NTHR  = 4,
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy_sel,
    input  logic [CW-1:0]      cap_limit,
    input  logic [NTHR-1:0]    thread_active,
    input  logic [NTHR-1:0]    alloc_req,
    input  logic [NTHR-1:0]    retire_req,
    output logic [NTHR*CW-1:0] thread_free,
    output logic [CW-1:0]      total_free,
    output logic [NTHR-1:0]    thread_stall
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [NTHR-1:0]    act_eff;
    logic [NTHR*CW-1:0] ceil_d;
    logic [NTHR*CW-1:0] ceil_q;
    logic [NTHR*CW-1:0] occ_flat;
    logic [NTHR-1:0]    room;
    logic [NTHR-1:0]    grant;
    logic [NTHR-1:0]    dec;
    logic [CW-1:0]      tot_q;
    logic [CW-1:0]      tot_d;

    // In reset every thread counts as active for the ceiling load.
    assign act_eff = rst_n ? thread_active : '1;

    rob_ceiling_calc #(.NTHR(NTHR), .DEPTH(DEPTH), .CW(CW)) u_ceil (
        .pol_i  (policy_sel),
        .cap_i  (cap_limit),
        .act_i  (act_eff),
        .ceil_o (ceil_d)
    );

    // Ceiling register, reloaded on every edge including reset.
    always_ff @(posedge clk) begin
        ceil_q <= ceil_d;
    end

    rob_grant_arb #(.NTHR(NTHR), .CW(CW)) u_arb (
        .req_i       (alloc_req),
        .room_i      (room),
        .glob_free_i (total_free),
        .grant_o     (grant)
    );

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [CW-1:0] occ;
        logic [CW-1:0] ceil_t;
        assign ceil_t = ceil_q[t*CW +: CW];
        assign dec[t] = retire_req[t] && (occ != '0);

        rob_occ_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (grant[t]),
            .dec_i (dec[t]),
            .occ_o (occ)
        );

        assign occ_flat[t*CW +: CW]    = occ;
        assign thread_free[t*CW +: CW] = (occ >= ceil_t) ? '0 : (ceil_t - occ);
        assign room[t]                 = (thread_free[t*CW +: CW] != '0);
        assign thread_stall[t]         = !room[t] || (total_free == '0);
    end

    // Next global total from this cycle's grants and releases.
    always_comb begin
        tot_d = tot_q + CW'($countones(grant)) - CW'($countones(dec));
    end

    // Global occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) tot_q <= '0;
        else        tot_q <= tot_d;
    end

    assign total_free = FULL - tot_q;
endmodule

// File: rtl/rob_slot_alloc_chk.sv
// Temporal checks for the slot budget tracker, bound into every instance.
module rob_slot_alloc_chk #(
    parameter int NTHR  = 4,
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         policy_sel,
    input logic [NTHR-1:0]    alloc_req,
    input logic [NTHR-1:0]    retire_req,
    input logic [CW-1:0]      total_free,
    input logic [NTHR-1:0]    thread_stall,
    input logic [NTHR*CW-1:0] ceil_q
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // R1
    dyn_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_sel == 2'b00) |=> (ceil_q == {NTHR{FULL}}));

    // R6
    glob_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_free <= FULL);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total_free == '0 && retire_req == '0) |=> (total_free == '0));

    // R9
    free_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req == '0) |=> (total_free >= $past(total_free)));

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total_free == '0) |-> (&thread_stall));
endmodule

bind rob_slot_alloc rob_slot_alloc_chk #(.NTHR(NTHR), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_sel   (policy_sel),
    .alloc_req    (alloc_req),
    .retire_req   (retire_req),
    .total_free   (total_free),
    .thread_stall (thread_stall),
    .ceil_q       (ceil_q)
);

// File: tb/rob_slot_alloc_bench.sv
module rob_slot_alloc_bench;
    localparam int NT = 4;
    localparam int DP = 10;
    localparam int W  = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    policy_sel;
    logic [W-1:0]  cap_limit;
    logic [NT-1:0] thread_active;
    logic [NT-1:0] alloc_req;
    logic [NT-1:0] retire_req;
    logic [NT*W-1:0] thread_free;
    logic [W-1:0]  total_free;
    logic [NT-1:0] thread_stall;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int m_occ  [NT];
    int m_ceil [NT];

    always #10 clk = ~clk;

    rob_slot_alloc #(.NTHR(NT), .DEPTH(DP)) u_rob_slot_alloc (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .cap_limit(cap_limit),
        .thread_active(thread_active), .alloc_req(alloc_req), .retire_req(retire_req),
        .thread_free(thread_free), .total_free(total_free), .thread_stall(thread_stall)
    );

    // Expected ceiling of thread t from the requirement text (R1, R2, R3).
    function automatic int f_ceil(input logic [1:0] pol, input int cap,
                                  input logic [NT-1:0] msk, input int t);
        int n = 0;
        for (int k = 0; k < NT; k++) n += msk[k];
        if (pol == 2'b01) return msk[t] ? ((n == 0) ? DP / NT : DP / n) : DP / NT;
        if (pol == 2'b10) return (msk[t] && n == 1) ? DP : ((cap > DP) ? DP : cap);
        return DP;
    endfunction

    function automatic int m_free(input int t);
        return (m_occ[t] >= m_ceil[t]) ? 0 : m_ceil[t] - m_occ[t];
    endfunction

    function automatic int m_gfree();
        int s = 0;
        for (int k = 0; k < NT; k++) s += m_occ[k];
        return DP - s;
    endfunction

    task automatic cmp(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output against the model, tagged with the step's requirement.
    task automatic check_all(input string tag);
        logic [NT-1:0] st;
        for (int t = 0; t < NT; t++) begin
            cmp(int'(thread_free[t*W +: W]), m_free(t), $sformatf("%s R5 free[%0d]", tag, t));
            st[t] = (m_free(t) == 0) || (m_gfree() == 0);
        end
        cmp(int'(total_free), m_gfree(), {tag, " R6 total"});
        cmp(int'(thread_stall), int'(st), {tag, " R7 stall"});
    endtask

    // One clock: drive at negedge, predict, then compare at the next negedge.
    task automatic step(input logic [1:0] pol, input int cap, input logic [NT-1:0] msk,
                        input logic [NT-1:0] al, input logic [NT-1:0] rt, input string tag);
        int nocc [NT];
        int used = 0;
        int g    = m_gfree();
        policy_sel = pol; cap_limit = W'(cap); thread_active = msk;
        alloc_req = al; retire_req = rt;
        for (int t = 0; t < NT; t++) begin
            bit gr = al[t] && (m_free(t) != 0) && (used < g);
            bit dc = rt[t] && (m_occ[t] != 0);
            used += gr;
            nocc[t] = m_occ[t] + gr - dc;
        end
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            m_occ[t]  = nocc[t];
            m_ceil[t] = f_ceil(pol, cap, msk, t);
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R11: reset in capped mode, cap 3, only thread 0 marked active.
        rst_n = 0; policy_sel = 2'b10; cap_limit = 3; thread_active = 4'b0001;
        alloc_req = 0; retire_req = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < NT; t++) begin m_occ[t] = 0; m_ceil[t] = 3; end
        check_all("R11 reset");
        rst_n = 1;
        // R3/R4: a lone active thread is raised to the full depth one cycle later.
        step(2'b10, 3, 4'b0001, 0, 0, "R3 R4 lone");
        step(2'b10, 15, 4'b0011, 0, 0, "R3 clamp");
        // R1: shared mode, thread 0 fills the buffer.
        for (int i = 0; i < 10; i++) step(2'b00, 0, 4'b1111, 4'b0001, 0, "R1 R8 fill");
        step(2'b00, 0, 4'b1111, 4'b1111, 0, "R8 full ignore");
        step(2'b11, 0, 4'b1111, 4'b0001, 4'b0001, "R1 R9 stalled retire");
        step(2'b00, 0, 4'b1111, 4'b1111, 0, "R8 one slot order");
        step(2'b00, 0, 4'b1111, 0, 4'b0011, "R9 release");
        step(2'b00, 0, 4'b1111, 4'b0001, 4'b0001, "R10 same cycle");
        step(2'b00, 0, 4'b1111, 0, 4'b1000, "R9 empty retire");
        // R2: split mode over several masks, uneven division included.
        step(2'b01, 0, 4'b1111, 0, 0, "R2 split4");
        step(2'b01, 0, 4'b0111, 0, 0, "R2 split3");
        step(2'b01, 0, 4'b0011, 0, 0, "R2 split2");
        step(2'b01, 0, 4'b0000, 0, 0, "R2 none");
        for (int i = 0; i < 10; i++) step(2'b01, 0, 4'b1111, 0, 4'b1111, "R9 drain");
        step(2'b01, 0, 4'b0110, 4'b0110, 0, "R2 R8 split claim");
        // Random traffic with a fixed seed.
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] p  = 2'($urandom_range(0, 3));
            int c          = $urandom_range(0, 15);
            logic [NT-1:0] mk = ($urandom_range(0, 7) == 0) ? NT'($urandom) : thread_active;
            step(p, c, mk, NT'($urandom), NT'($urandom) & NT'($urandom), "R4 R8 R10 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule